// File: doc/BRIEF.md
# Folded Single-Multiplier FIR Filter

This block is a finite impulse response filter in which one signed multiplier and one accumulator serve every tap in turn. The processing clock runs at an integer multiple of the sample rate: each accepted input sample opens a fold of `TAPS` processing cycles. During a fold a small counter steps a selector across the stored history, so that the newest sample comes first and the oldest last. A constant coefficient table is read with the same index, so each delayed sample meets its own weight.

The products are summed in a wide accumulator. The finished sum is rounded and saturated back to the input format. The result then appears on the output with a one-cycle valid strobe. The filter is meant for streams where `in_valid` pulses at most once per fold, with the sample held on `in_sample` while the strobe is high. Samples and coefficients are signed fractions in [-1, 1), written with `W` and `CW` bits.

Top module: `tdm_fir`

## Requirements
- R1: Synchronous active-high reset clears the sample history, the step counter and the accumulator. While and after reset, `out_valid` is 0 and `out_sample` is 0. The first outputs after reset treat the history that was never filled as zero.
- R2: The output for the sample accepted in fold n equals the sum over k = 0..TAPS-1 of c[k]·x(n-k), where x(n) is the newest sample. Tap k's coefficient sits at bits [k·CW +: CW] of `COEFS` as a two's-complement Q1.(CW-1) value.
- R3: The full-precision sum is brought back to Q1.(W-1) by adding 2^(CW-2) and shifting right arithmetically by CW-1, which rounds halves toward +infinity.
- R4: A rounded result above 2^(W-1)-1 is output as 2^(W-1)-1, and one below -2^(W-1) is output as -2^(W-1). The accumulator carries ceil(log2(TAPS)) guard bits, so no partial sum wraps even when every product has the largest magnitude and the same sign.
- R5: `out_valid` rises exactly TAPS clock cycles after the edge that sampled `in_valid`, and it stays high for one cycle per completed fold.
- R6: Inputs may arrive at any period of TAPS cycles or more. `in_sample` is ignored in every cycle where `in_valid` is low.
- R7: When `in_valid` arrives before the running fold has finished, that fold is dropped and gives no output. The new sample still enters the history behind the one that was dropped, and a new fold starts at once.
- R8: `out_sample` holds its last value in every cycle where `out_valid` is low.
- R9: Within a fold, the tap index starts at 0 on the edge that accepts a sample and rises by one per cycle up to TAPS-1. It never exceeds TAPS-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processing clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pulses once per accepted input sample |
| in_sample | input | W | Signed Q1.(W-1) input sample |
| out_valid | output | 1 | One-cycle strobe marking a new filtered sample |
| out_sample | output | W | Signed Q1.(W-1) rounded and saturated output |

## Verification
The bench builds the filter with four taps, 16-bit samples and coefficients {32767, -32768, 24576, -8192}. The absolute values of these coefficients add up to almost three, so a few alternating full-scale samples drive the exact sum past 32 bits. That brings both saturation limits and the guard bits within reach. The small coefficient count also lets the bench sweep the input amplitude across the whole 16-bit range, step through the rounding of tiny values one LSB at a time, and test every input period from a restart two cycles into a fold up to long idle gaps.

// File: rtl/tdm_fir_pkg.sv
package tdm_fir_pkg;

    localparam int DEF_W    = 16;
    localparam int DEF_TAPS = 4;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // Per-cycle control word that travels from the sequencer to the MAC.
    typedef struct packed {
        logic active;
        logic first;
        logic last;
    } step_t;

    function automatic int guard_bits(input int taps);
        return (taps <= 1) ? 1 : $clog2(taps);
    endfunction

    function automatic int index_bits(input int taps);
        return (taps <= 1) ? 1 : $clog2(taps);
    endfunction

endpackage

// File: rtl/tdm_fir_delay.sv
module tdm_fir_delay #(
    parameter int W    = 16,
    parameter int TAPS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift,
    input  logic [W-1:0]      din,
    output logic [TAPS*W-1:0] hist
);
    logic [W-1:0] stage [TAPS];

    // stage[0] is the newest sample, stage[TAPS-1] the oldest.
    always_ff @(posedge clk) begin
        if (rst) begin
            stage[0] <= '0;
        end else if (shift) begin
            stage[0] <= din;
        end
    end

    for (genvar i = 1; i < TAPS; i++) begin : g_shift
        always_ff @(posedge clk) begin
            if (rst) begin
                stage[i] <= '0;
            end else if (shift) begin
                stage[i] <= stage[i-1];
            end
        end
    end

    for (genvar i = 0; i < TAPS; i++) begin : g_flat
        assign hist[i*W +: W] = stage[i];
    end

endmodule

// File: rtl/tdm_fir_seq.sv
module tdm_fir_seq
    import tdm_fir_pkg::*;
#(
    parameter int TAPS  = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic [SEL_W-1:0] sel,
    output step_t            step
);
    localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(TAPS - 1);

    phase_e           phase;
    logic [SEL_W-1:0] cnt;

    // A start always wins: it restarts the index even in mid-fold.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (start) begin
            phase <= PH_RUN;
            cnt   <= '0;
        end else if (phase == PH_RUN) begin
            if (cnt == LAST_IDX) begin
                phase <= PH_IDLE;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign sel         = cnt;
    assign step.active = (phase == PH_RUN);
    assign step.first  = (cnt == '0);
    assign step.last   = (cnt == LAST_IDX);

endmodule

// File: rtl/tdm_fir_mac.sv
module tdm_fir_mac
    import tdm_fir_pkg::*;
#(
    parameter int W     = 16,
    parameter int CW    = 16,
    parameter int ACC_W = 34
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [W-1:0]     sample,
    input  logic signed [CW-1:0]    coef,
    input  step_t                   step,
    output logic signed [ACC_W-1:0] sum,
    output logic                    sum_valid
);
    localparam int P_W = W + CW;

    logic signed [P_W-1:0]   prod;
    logic signed [ACC_W-1:0] prod_ext;
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] acc_next;

    assign prod     = sample * coef;
    assign prod_ext = ACC_W'(prod);
    assign acc_next = step.first ? prod_ext : (acc + prod_ext);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            sum       <= '0;
            sum_valid <= 1'b0;
        end else begin
            sum_valid <= step.active && step.last;
            if (step.active) begin
                acc <= acc_next;
                if (step.last) begin
                    sum <= acc_next;
                end
            end
        end
    end

endmodule

// File: rtl/tdm_fir_round.sv
module tdm_fir_round #(
    parameter int IN_W  = 34,
    parameter int OUT_W = 16,
    parameter int FRAC  = 15
) (
    input  logic signed [IN_W-1:0]  din,
    output logic signed [OUT_W-1:0] dout
);
    localparam int BW = IN_W + 1;

    localparam logic signed [BW-1:0] HALF = BW'(1) << (FRAC - 1);
    localparam logic signed [BW-1:0] HI   = {{(BW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [BW-1:0] LO   = {{(BW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic signed [BW-1:0] biased;
    logic signed [BW-1:0] shifted;

    assign biased  = BW'(din) + HALF;
    assign shifted = biased >>> FRAC;

    always_comb begin
        if (shifted > HI) begin
            dout = HI[OUT_W-1:0];
        end else if (shifted < LO) begin
            dout = LO[OUT_W-1:0];
        end else begin
            dout = shifted[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/tdm_fir.sv
module tdm_fir
    import tdm_fir_pkg::*;
#(
    parameter int              W     = DEF_W,
    parameter int              CW    = 16,
    parameter int              TAPS  = DEF_TAPS,
    parameter logic [TAPS*CW-1:0] COEFS = {16'hE000, 16'h6000, 16'h8000, 16'h7FFF}
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_sample,
    output logic         out_valid,
    output logic [W-1:0] out_sample
);
    localparam int SEL_W = index_bits(TAPS);
    localparam int G_W   = guard_bits(TAPS);
    localparam int ACC_W = W + CW + G_W;

    logic [TAPS*W-1:0]       hist;
    logic [SEL_W-1:0]        sel;
    step_t                   step;
    logic signed [W-1:0]     cur_sample;
    logic signed [CW-1:0]    cur_coef;
    logic signed [ACC_W-1:0] sum;
    logic signed [W-1:0]     rounded;

    logic signed [W-1:0]  hist_arr  [TAPS];
    logic signed [CW-1:0] coef_rom  [TAPS];

    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        assign hist_arr[i] = hist[i*W +: W];
        assign coef_rom[i] = COEFS[i*CW +: CW];
    end

    tdm_fir_delay #(
        .W    (W),
        .TAPS (TAPS)
    ) u_delay (
        .clk   (clk),
        .rst   (rst),
        .shift (in_valid),
        .din   (in_sample),
        .hist  (hist)
    );

    tdm_fir_seq #(
        .TAPS  (TAPS),
        .SEL_W (SEL_W)
    ) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (in_valid),
        .sel   (sel),
        .step  (step)
    );

    assign cur_sample = hist_arr[sel];
    assign cur_coef   = coef_rom[sel];

    tdm_fir_mac #(
        .W     (W),
        .CW    (CW),
        .ACC_W (ACC_W)
    ) u_mac (
        .clk       (clk),
        .rst       (rst),
        .sample    (cur_sample),
        .coef      (cur_coef),
        .step      (step),
        .sum       (sum),
        .sum_valid (out_valid)
    );

    tdm_fir_round #(
        .IN_W  (ACC_W),
        .OUT_W (W),
        .FRAC  (CW - 1)
    ) u_round (
        .din  (sum),
        .dout (rounded)
    );

    assign out_sample = rounded;

endmodule

// File: rtl/tdm_fir_checker.sv
module tdm_fir_checker #(
    parameter int W     = 16,
    parameter int TAPS  = 4,
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             out_valid,
    input logic [W-1:0]     out_sample,
    input logic [SEL_W-1:0] sel,
    input logic             active
);
    localparam int LW = SEL_W + 3;
    localparam logic [LW-1:0] LMAX = '1;
    localparam logic [LW-1:0] TAPS_L = LW'(TAPS);

    // Cycles since the last accepted sample, and the spacing seen at that sample.
    logic [LW-1:0] since;
    logic [LW-1:0] gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            since <= LMAX;
            gap   <= LMAX;
        end else if (in_valid) begin
            since <= '0;
            gap   <= (since == LMAX) ? LMAX : since + 1'b1;
        end else if (since != LMAX) begin
            since <= since + 1'b1;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && out_sample == '0)); // R1

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (since == TAPS_L || (since == '0 && gap == TAPS_L))); // R5

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && TAPS > 1) |=> !out_valid); // R5

    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_sample)); // R8

    AST_RESTART: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (active && sel == '0)); // R9

    AST_STEP: assert property (@(posedge clk) disable iff (rst)
        (active && !in_valid && sel != SEL_W'(TAPS - 1)) |=> (active && sel == $past(sel) + 1'b1)); // R9

    AST_SEL_RANGE: assert property (@(posedge clk) disable iff (rst)
        sel <= SEL_W'(TAPS - 1)); // R9

endmodule

bind tdm_fir tdm_fir_checker #(
    .W     (W),
    .TAPS  (TAPS),
    .SEL_W (SEL_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .out_sample (out_sample),
    .sel        (sel),
    .active     (step.active)
);

// File: tb/tdm_fir_test.sv
module tdm_fir_test;
    localparam int W    = 16;
    localparam int CW   = 16;
    localparam int TAPS = 4;
    localparam logic [TAPS*CW-1:0] COEFS = {16'hE000, 16'h6000, 16'h8000, 16'h7FFF};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_sample = '0;
    logic         out_valid;
    logic [W-1:0] out_sample;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    int    coef [TAPS] = '{32767, -32768, 24576, -8192};
    int    hist [TAPS];
    int    exp_q [$];
    int    due_q [$];
    string tag_q [$];
    string cur_tag = "R2";

    tdm_fir #(.W(W), .CW(CW), .TAPS(TAPS), .COEFS(COEFS)) uut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int ref_out();
        longint acc = 0;
        longint r;
        for (int k = 0; k < TAPS; k++) acc += longint'(coef[k]) * longint'(hist[k]);
        r = (acc + 64'sd16384) >>> 15;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    task automatic check(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    // Output monitor: compares every strobe with the reference queue.
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (due_q.size() > 0 && cyc == due_q[0]) begin
                check({tag_q[0], " out_valid at due cycle"}, int'(out_valid), 1);
                check({tag_q[0], " out_sample"}, int'($signed(out_sample)), exp_q[0]);
                void'(due_q.pop_front());
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
            end else if (out_valid) begin
                check("R5/R7 unexpected out_valid", 1, 0);
            end
        end
    end

    task automatic clear_model();
        for (int k = 0; k < TAPS; k++) hist[k] = 0;
        exp_q.delete();
        due_q.delete();
        tag_q.delete();
    endtask

    // One accepted sample; the strobe is high for a single cycle.
    task automatic pulse(input int x);
        @(negedge clk);
        if (due_q.size() > 0 && due_q[$] > cyc + 1) begin
            void'(due_q.pop_back());
            void'(exp_q.pop_back());
            void'(tag_q.pop_back());
        end
        in_valid  = 1'b1;
        in_sample = W'(x);
        for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
        exp_q.push_back(ref_out());
        due_q.push_back(cyc + TAPS + 1);
        tag_q.push_back(cur_tag);
        @(negedge clk);
        in_valid  = 1'b0;
        in_sample = W'(cyc * 7919 + 12345);   // junk while idle (R6)
    endtask

    task automatic pulse_period(input int x, input int period);
        pulse(x);
        repeat (period - 2) begin
            @(negedge clk);
            in_sample = W'(cyc * 31337);
        end
    endtask

    task automatic drain();
        repeat (TAPS + 3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        clear_model();
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", int'(out_valid), 0);
        check("R1 out_sample in reset", int'($signed(out_sample)), 0);
        rst = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        clear_model();
        do_reset();

        // R1/R2: impulse straight after reset, empty history is zero.
        cur_tag = "R1";
        pulse_period(8000, TAPS + 1);
        cur_tag = "R2";
        for (int i = 0; i < TAPS; i++) pulse_period(0, TAPS + 1);
        drain();

        // R2/R6: amplitude sweep over the full range, period TAPS+1 with junk between.
        cur_tag = "R6";
        for (int v = -32768; v <= 32767; v += 997) pulse_period(v, TAPS + 1);
        drain();

        // R3: small values expose rounding of each tap product.
        cur_tag = "R3";
        for (int v = -6; v <= 6; v++) pulse_period(v, TAPS);
        for (int i = 0; i < TAPS; i++) pulse_period(0, TAPS);
        drain();

        // R4: alternating full scale drives both saturation limits and the guard bits.
        cur_tag = "R4";
        for (int r = 0; r < 3; r++) begin
            pulse_period(32767, TAPS);
            pulse_period(-32768, TAPS);
        end
        pulse_period(-32768, TAPS);
        pulse_period(-32768, TAPS);
        pulse_period(32767, TAPS);
        pulse_period(32767, TAPS);
        drain();

        // R5: back-to-back folds at exactly TAPS cycles, then long gaps.
        cur_tag = "R5";
        for (int i = 0; i < 20; i++) pulse_period(i * 1500 - 14000, TAPS);
        for (int i = 0; i < 6; i++) pulse_period(i * 4000 - 9000, TAPS + 7);
        drain();

        // R7: a restart two cycles into a fold drops it; history still shifts.
        cur_tag = "R7";
        pulse_period(12000, 2);
        pulse_period(-7000, TAPS);
        pulse_period(3000, 3);
        pulse_period(20000, TAPS + 2);
        drain();

        // R1: reset in mid-fold clears the pending result and the history.
        cur_tag = "R1";
        pulse_period(30000, TAPS);
        pulse(25000);
        do_reset();
        pulse_period(-20000, TAPS + 1);
        pulse_period(0, TAPS + 1);
        drain();

        // R8: output holds while idle.
        repeat (5) @(negedge clk);
        check("R8 out_sample held", int'($signed(out_sample)), exp_q.size() == 0 ? ref_out() : 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule